// File: doc/BRIEF.md
# Stacked Cache Bank Placement Allocator

This block hands out the banks of a stacked L2 cache to the processor cores of a multicore die. Eight cores sit on a 2x4 grid, and four cache layers are stacked above them. Each layer holds four banks above every core. The banks above one core, across all layers, form that core's zone of 16 banks, out of 128 banks in total. Software or a controller supplies one requested bank count per core and pulses start. The block checks the request set, runs a fixed placement order one bank per clock, and fills an ownership table that maps each bank to a core.

The placement order works as follows. Cores that ask for less than a full zone are served first, from their own zone, in ascending order of request. Cores that ask for a full zone or more then take their whole zone. The banks they still need are handed out one core at a time, and the core with the fewest banks still owed goes first. Each of those banks comes from the nearest zone that still has free banks. The table can be read at any time through a combinational port indexed by bank number. A single-cycle done pulse marks the end of a run, and an error flag reports a rejected request set.

Top module: `bank_alloc`

## Requirements
- R1: After reset, busy, done and err are 0 and every bank reads as unowned (rd_owned = 0).
- R2: Bank number b = layer*32 + zone*4 + k, with layer in 0..3 and k in 0..3, so the zone of bank b is (b/4) mod 8. Within a zone, banks are handed out lowest layer first, then lowest k. This gives zone slot s = layer*4 + k.
- R3: When all eight requests equal 16, each core owns exactly the 16 banks of its own zone.
- R4: A core requesting n < 16 banks owns slots 0..n-1 of its own zone. The other slots of that zone stay free for the overflow phase.
- R5: A core requesting n >= 16 owns all 16 banks of its own zone, and n-16 banks are still owed to it.
- R6: Owed banks are served one core at a time. The core with the fewest banks still owed goes first, and ties go to the lower core index. That core is served until nothing is owed to it.
- R7: Each owed bank comes from the zone with free banks that has the smallest Manhattan distance to the core. Core and zone c sit at row c/4, column c mod 4. Ties go to the lower zone index, and within the zone the next slot is used in the R2 order.
- R8: After a valid run, every bank is owned exactly once, and each core owns exactly the number of banks it requested.
- R9: If any request is 0 or above 128, or the requests do not sum to 128, err goes to 1, the table stays fully unowned, and done still pulses.
- R10: done is high for exactly one cycle at the end of a run, and busy is 0 in that cycle. busy is 1 from the cycle after an accepted start. err holds its value until the next accepted start, and a valid run leaves it at 0.
- R11: A start pulse while busy is 1 is ignored. The run in progress completes with its original requests.
- R12: rd_owned and rd_core follow rd_bank combinationally, with no clock edge between a change of rd_bank and the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a placement run (taken only while idle) |
| req_flat | input | 64 | Eight 8-bit bank requests, core c at bits [8c+7:8c] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| err | output | 1 | Last request set was rejected |
| rd_bank | input | 7 | Bank number to look up |
| rd_owned | output | 1 | The looked-up bank has an owner |
| rd_core | output | 3 | Owner core of the looked-up bank |

## Verification
The all-16 pattern confirms the zone and bank numbering on its own, because no overflow occurs. A mixed pattern with small and large requests separates own-zone service from overflow, and an ascending ramp and a tied-owe pattern test the fewest-owed order and its tie-break. An eight-run sweep gives one core 121 banks and every other core one bank, so the nearest-zone walk and its lower-index tie-break run from every grid position. Three malformed request sets (bad sum, a zero, an oversize count), and a start pulse issued mid-run, test rejection and the ignoring of new requests while busy.

// File: rtl/bank_alloc_pkg.sv
package bank_alloc_pkg;

    parameter int NUM_CORES       = 8;
    parameter int NUM_LAYERS      = 4;
    parameter int BANKS_PER_SLICE = 4;
    parameter int GRID_COLS       = 4;

    localparam int GRID_ROWS   = NUM_CORES / GRID_COLS;
    localparam int ZONE_BANKS  = NUM_LAYERS * BANKS_PER_SLICE;
    localparam int LAYER_BANKS = NUM_CORES * BANKS_PER_SLICE;
    localparam int TOTAL_BANKS = LAYER_BANKS * NUM_LAYERS;
    localparam int CORE_W      = $clog2(NUM_CORES);
    localparam int BANK_W      = $clog2(TOTAL_BANKS);
    localparam int CNT_W       = $clog2(TOTAL_BANKS + 1);
    localparam int SLOT_W      = $clog2(ZONE_BANKS + 1);
    localparam int DIST_W      = $clog2(GRID_ROWS + GRID_COLS);

    typedef logic [CORE_W-1:0] core_id_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [DIST_W-1:0] dist_t;

    typedef struct packed {
        logic     owned;
        core_id_t core;
    } owner_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_OWN,
        ST_SPILL
    } phase_t;

    // bank number of slot 'slot' in zone 'zone' (lowest layer first)
    function automatic bank_t bank_of(input int zone, input int slot);
        int v;
        v = (slot / BANKS_PER_SLICE) * LAYER_BANKS
          + zone * BANKS_PER_SLICE
          + (slot % BANKS_PER_SLICE);
        return bank_t'(v);
    endfunction

    // Manhattan distance between two grid positions
    function automatic dist_t hop_dist(input int a, input int b);
        int dr;
        int dc;
        dr = (a / GRID_COLS) - (b / GRID_COLS);
        dc = (a % GRID_COLS) - (b % GRID_COLS);
        if (dr < 0) dr = -dr;
        if (dc < 0) dc = -dc;
        return dist_t'(dr + dc);
    endfunction

endpackage

// File: rtl/min_pick.sv
module min_pick #(
    parameter int N  = 8,
    parameter int KW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]    cand,
    input  logic [N*KW-1:0] keys,
    output logic            found,
    output logic [IW-1:0]   idx
);

    logic [KW-1:0] best;

    // strict less-than keeps the lowest index on ties
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || keys[i*KW +: KW] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = keys[i*KW +: KW];
            end
        end
    end

endmodule

// File: rtl/req_check.sv
module req_check
    import bank_alloc_pkg::*;
(
    input  logic [NUM_CORES*CNT_W-1:0] req_flat,
    output logic                       req_ok
);

    localparam int SUM_W = CNT_W + CORE_W;

    logic [SUM_W-1:0] total;
    logic             in_range;
    cnt_t             one_req;

    always_comb begin
        total    = '0;
        in_range = 1'b1;
        one_req  = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            one_req = req_flat[c*CNT_W +: CNT_W];
            total   = total + SUM_W'(one_req);
            if (one_req == '0 || one_req > cnt_t'(TOTAL_BANKS))
                in_range = 1'b0;
        end
        req_ok = in_range && (total == SUM_W'(TOTAL_BANKS));
    end

endmodule

// File: rtl/bank_alloc.sv
module bank_alloc
    import bank_alloc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [NUM_CORES*CNT_W-1:0] req_flat,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    input  logic [BANK_W-1:0]          rd_bank,
    output logic                       rd_owned,
    output logic [CORE_W-1:0]          rd_core
);

    phase_t phase;
    cnt_t   req_q    [NUM_CORES];
    cnt_t   own_left [NUM_CORES];
    cnt_t   owe      [NUM_CORES];
    slot_t  fill     [NUM_CORES];
    owner_t table_q  [TOTAL_BANKS];
    logic   done_q;
    logic   err_q;

    // ---------------- request validation ----------------
    logic [NUM_CORES*CNT_W-1:0] req_vec;
    logic                       req_ok;

    always_comb begin
        for (int c = 0; c < NUM_CORES; c++)
            req_vec[c*CNT_W +: CNT_W] = req_q[c];
    end

    req_check u_check (
        .req_flat (req_vec),
        .req_ok   (req_ok)
    );

    // ---------------- candidate selection ----------------
    logic [NUM_CORES-1:0]        own_cand, spill_cand, zone_cand;
    logic [NUM_CORES*CNT_W-1:0]  own_keys, spill_keys;
    logic [NUM_CORES*DIST_W-1:0] zone_keys;
    logic                        own_found, spill_found, zone_found;
    core_id_t                    own_idx, spill_idx, zone_idx;

    generate
        for (genvar g = 0; g < NUM_CORES; g++) begin : g_keys
            assign own_cand[g]                    = own_left[g] != '0;
            assign own_keys[g*CNT_W +: CNT_W]     = req_q[g];
            assign spill_cand[g]                  = owe[g] != '0;
            assign spill_keys[g*CNT_W +: CNT_W]   = owe[g];
            assign zone_cand[g]                   = fill[g] != slot_t'(ZONE_BANKS);
            assign zone_keys[g*DIST_W +: DIST_W]  = hop_dist(int'(spill_idx), g);
        end
    endgenerate

    min_pick #(.N(NUM_CORES), .KW(CNT_W)) u_own_pick (
        .cand (own_cand), .keys (own_keys), .found (own_found), .idx (own_idx)
    );

    min_pick #(.N(NUM_CORES), .KW(CNT_W)) u_spill_pick (
        .cand (spill_cand), .keys (spill_keys), .found (spill_found), .idx (spill_idx)
    );

    min_pick #(.N(NUM_CORES), .KW(DIST_W)) u_zone_pick (
        .cand (zone_cand), .keys (zone_keys), .found (zone_found), .idx (zone_idx)
    );

    // ---------------- write port ----------------
    logic     wr_en;
    core_id_t wr_core;
    core_id_t wr_zone;
    bank_t    wr_bank;

    always_comb begin
        wr_en   = 1'b0;
        wr_core = '0;
        wr_zone = '0;
        if (phase == ST_OWN && own_found) begin
            wr_en   = 1'b1;
            wr_core = own_idx;
            wr_zone = own_idx;
        end else if (phase == ST_SPILL && spill_found && zone_found) begin
            wr_en   = 1'b1;
            wr_core = spill_idx;
            wr_zone = zone_idx;
        end
        wr_bank = bank_of(int'(wr_zone), int'(fill[wr_zone]));
    end

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= ST_IDLE;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            for (int c = 0; c < NUM_CORES; c++) begin
                req_q[c]    <= '0;
                own_left[c] <= '0;
                owe[c]      <= '0;
                fill[c]     <= '0;
            end
            for (int b = 0; b < TOTAL_BANKS; b++)
                table_q[b] <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                ST_IDLE: begin
                    if (start) begin
                        for (int c = 0; c < NUM_CORES; c++)
                            req_q[c] <= req_flat[c*CNT_W +: CNT_W];
                        for (int b = 0; b < TOTAL_BANKS; b++)
                            table_q[b] <= '0;
                        err_q <= 1'b0;
                        phase <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!req_ok) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                        phase  <= ST_IDLE;
                    end else begin
                        for (int c = 0; c < NUM_CORES; c++) begin
                            if (req_q[c] < cnt_t'(ZONE_BANKS)) begin
                                own_left[c] <= req_q[c];
                                owe[c]      <= '0;
                            end else begin
                                own_left[c] <= cnt_t'(ZONE_BANKS);
                                owe[c]      <= req_q[c] - cnt_t'(ZONE_BANKS);
                            end
                            fill[c] <= '0;
                        end
                        phase <= ST_OWN;
                    end
                end
                ST_OWN: begin
                    if (own_found)
                        own_left[own_idx] <= own_left[own_idx] - 1'b1;
                    else
                        phase <= ST_SPILL;
                end
                ST_SPILL: begin
                    if (spill_found) begin
                        owe[spill_idx] <= owe[spill_idx] - 1'b1;
                    end else begin
                        done_q <= 1'b1;
                        phase  <= ST_IDLE;
                    end
                end
                default: phase <= ST_IDLE;
            endcase
            if (wr_en) begin
                table_q[wr_bank] <= '{owned: 1'b1, core: wr_core};
                fill[wr_zone]    <= fill[wr_zone] + 1'b1;
            end
        end
    end

    assign busy     = phase != ST_IDLE;
    assign done     = done_q;
    assign err      = err_q;
    assign rd_owned = table_q[rd_bank].owned;
    assign rd_core  = table_q[rd_bank].core;

    // ---------------- assertions ----------------
    logic any_owned;
    always_comb begin
        any_owned = 1'b0;
        for (int b = 0; b < TOTAL_BANKS; b++)
            any_owned = any_owned | table_q[b].owned;
    end

    assert_fresh_bank_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !table_q[wr_bank].owned);

    assert_zone_bound_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> fill[wr_zone] < slot_t'(ZONE_BANKS));

    assert_rejected_clear_R9: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !any_owned);

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> done_q);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_IDLE && start) |=> phase != ST_CHECK);

endmodule

// File: tb/bank_alloc_test.sv
`timescale 1ns/10ps
module bank_alloc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [63:0] req_flat = '0;
    logic       busy, done, err;
    logic [6:0] rd_bank = '0;
    logic       rd_owned;
    logic [2:0] rd_core;

    int checks = 0;
    int errors = 0;
    int exp_own [128];

    always #2.5 clk = ~clk;

    bank_alloc uut (
        .clk (clk), .rst (rst), .start (start), .req_flat (req_flat),
        .busy (busy), .done (done), .err (err),
        .rd_bank (rd_bank), .rd_owned (rd_owned), .rd_core (rd_core)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int zbank(input int z, input int s);
        return (s / 4) * 32 + z * 4 + (s % 4);
    endfunction

    function automatic int mdist(input int a, input int b);
        int dr, dc;
        dr = a / 4 - b / 4; dc = a % 4 - b % 4;
        if (dr < 0) dr = -dr;
        if (dc < 0) dc = -dc;
        return dr + dc;
    endfunction

    // expected table built straight from the placement rules
    task automatic model(input int r[8]);
        int fl[8];
        int ow[8];
        bit done_c[8];
        for (int b = 0; b < 128; b++) exp_own[b] = -1;
        for (int i = 0; i < 8; i++) begin fl[i] = 0; ow[i] = 0; done_c[i] = 0; end
        for (int n = 0; n < 8; n++) begin
            int c = -1;
            int take;
            for (int i = 0; i < 8; i++)
                if (!done_c[i] && (c < 0 || r[i] < r[c])) c = i;
            done_c[c] = 1;
            take = (r[c] < 16) ? r[c] : 16;
            for (int s = 0; s < take; s++) exp_own[zbank(c, s)] = c;
            fl[c] = take;
            ow[c] = r[c] - take;
        end
        while (1) begin
            int c = -1;
            for (int i = 0; i < 8; i++)
                if (ow[i] > 0 && (c < 0 || ow[i] < ow[c])) c = i;
            if (c < 0) break;
            while (ow[c] > 0) begin
                int z = -1;
                for (int j = 0; j < 8; j++)
                    if (fl[j] < 16 && (z < 0 || mdist(c, j) < mdist(c, z))) z = j;
                exp_own[zbank(z, fl[z])] = c;
                fl[z]++;
                ow[c]--;
            end
        end
    endtask

    task automatic read_bank(input int b, output int v);
        rd_bank = 7'(b);
        #0.01;
        v = rd_owned ? int'(rd_core) : -1;
    endtask

    task automatic compare_table(input string req);
        int bad = 0;
        int fa = 0, fe = 0;
        int v;
        for (int b = 0; b < 128; b++) begin
            read_bank(b, v);
            if (v != exp_own[b]) begin
                if (bad == 0) begin fa = v; fe = exp_own[b]; end
                bad++;
            end
        end
        chk(bad == 0, req, fa, fe);
    endtask

    task automatic drive(input int r[8]);
        for (int c = 0; c < 8; c++) req_flat[c*8 +: 8] = 8'(r[c]);
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        chk(done == 1'b1, {req, " done seen"}, int'(done), 1);
        chk(busy == 1'b0, "R10 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    task automatic run(input int r[8], input string req, input bit bad);
        @(negedge clk);
        drive(r);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        wait_done(req);
        chk(err == bad, bad ? "R9 err set" : "R10 err clear", int'(err), int'(bad));
        if (bad) for (int b = 0; b < 128; b++) exp_own[b] = -1;
        else model(r);
        compare_table(req);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && err == 0, "R1 idle flags", int'({busy, done, err}), 0);
        for (int b = 0; b < 128; b++) exp_own[b] = -1;
        compare_table("R1 unowned table");

        // R3 and R2: equal requests
        run('{16,16,16,16,16,16,16,16}, "R3 equal split", 0);
        // R12 read port follows address with no clock
        read_bank(5, v);
        read_bank(127, v2);
        chk(v == 1 && v2 == 7, "R12 combinational read", v * 10 + v2, 17);
        read_bank(zbank(6, 9), v);
        chk(v == 6, "R2 zone slot numbering", v, 6);

        // R4 R5 R7 mixed small and large
        run('{4,28,16,8,20,12,24,16}, "R4 R5 R7 mixed", 0);
        // R6 ascending ramp, then tied owes
        run('{2,6,10,14,18,22,26,30}, "R6 ramp", 0);
        run('{1,1,31,31,16,16,16,16}, "R6 tie lower core", 0);
        run('{30,30,30,30,2,2,2,2}, "R8 four spill cores", 0);

        // R7 nearest-zone walk from every core
        for (int k = 0; k < 8; k++) begin
            int r[8];
            for (int i = 0; i < 8; i++) r[i] = (i == k) ? 121 : 1;
            run(r, "R7 sweep large core", 0);
        end

        // R9 rejected sets
        run('{16,16,16,16,16,16,16,15}, "R9 sum short", 1);
        run('{0,32,16,16,16,16,16,16}, "R9 zero request", 1);
        run('{255,1,1,1,1,1,1,1}, "R9 oversize request", 1);
        run('{8,24,16,16,16,16,16,16}, "R10 err cleared on good run", 0);

        // R11 start while busy is ignored
        @(negedge clk);
        drive('{4,28,16,8,20,12,24,16});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        drive('{16,16,16,16,16,16,16,15});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R11 run continues");
        chk(err == 1'b0, "R11 no err from ignored start", int'(err), 0);
        model('{4,28,16,8,20,12,24,16});
        compare_table("R11 original requests kept");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule